// File: doc/BRIEF.md
# Alternating Shifted Run-Length Decoder

This block is an on-chip test-data decompressor. A tester sends codewords over one serial channel, one bit per slow tester cycle. The decoder expands each codeword into a run of identical bits and shifts that run into a scan chain at the faster scan clock. Runs alternate between 0s and 1s, so every codeword carries only a length.

Lengths use variable-size groups, so short runs get short codewords. The code table is shifted up by one: a zero-length run never occurs, and the shortest codeword means a run of one bit.

The tester side uses a valid/ready handshake on the scan clock. A slow tester shows up as valid being high only every few cycles. The scan side drives one data bit and a shift enable.

Top module: `asfdr_decoder`

## Requirements
- R1: After reset, `scan_en` is 0, `tst_ready` is 1 and `dec_err` is 0.
- R2: A codeword of group k (k ≥ 1) has these fields in this order:
  - k−1 ones;
  - a single zero;
  - a k-bit tail, sent most significant bit first.

  It decodes to a run of 2^k − 1 + tail bits, so group k covers lengths 2^k − 1 to 2^(k+1) − 2.
- R3: The shortest codewords encode the shortest runs: `00` gives a run of 1 and `01` gives a run of 2. No codeword gives a run of 0.
- R4: The first run after reset is 0s. The run value toggles after every decoded run, and `scan_data` holds one value for the whole of a run.
- R5: `scan_en` is high for exactly the run length, in consecutive cycles. It starts in the cycle right after the edge that accepts the last tail bit.
- R6: `tst_ready` is low while a run is being emitted. A bit offered with `tst_valid` high while `tst_ready` is low is not consumed.
- R7: With the default `MAX_GROUP` of 10, runs of 2000 and 2046 bits (all-ones tail) decode correctly.
- R8: A prefix of `MAX_GROUP` ones sets `dec_err`. The flag is sticky until reset. While it is set, `tst_ready` is 0 and `scan_en` stays 0.
- R9: Bits are taken only on edges where both `tst_valid` and `tst_ready` are high. Idle gaps between tester bits do not change the decoded runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tst_valid | input | 1 | Tester bit is present |
| tst_bit | input | 1 | Serial codeword bit |
| tst_ready | output | 1 | Decoder can take a bit |
| scan_en | output | 1 | Shift enable for the scan chain |
| scan_data | output | 1 | Bit shifted into the scan chain |
| dec_err | output | 1 | Sticky prefix-overflow flag |

## Verification
The bench builds the decoder with the default `MAX_GROUP` of 10. This puts both the 2000-bit run and the largest group's 2046-bit run within reach, and a ten-ones prefix reaches the overflow flag in a few cycles. The tester is modelled with a gap of several idle cycles between bits. Each decoded run is measured at the scan port for length, value and start cycle, against an encoder written in the bench.

// File: rtl/asfdr_pkg.sv
// Shared types for the alternating shifted run-length decoder.
package asfdr_pkg;
    // Parser phase: reading the unary group prefix, or the binary tail.
    typedef enum logic {
        PH_PREFIX = 1'b0,
        PH_TAIL   = 1'b1
    } phase_t;
endpackage

// File: rtl/asfdr_cw_parser.sv
// Codeword parser. Takes one accepted bit per strobe and tracks the
// prefix ones and the tail bits. On the last tail bit it raises load with
// the run length. Assumes MAX_GROUP >= 2 and that LEN_W holds 2^(MAX_GROUP+1)-2.
module asfdr_cw_parser
    import asfdr_pkg::*;
#(
    parameter int MAX_GROUP = 10,
    parameter int GRP_W     = 4,
    parameter int LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             bit_in,
    output logic             load,
    output logic [LEN_W-1:0] run_len,
    output logic             err
);
    phase_t                 phase;
    logic [GRP_W-1:0]       ones;
    logic [GRP_W-1:0]       grp;
    logic [GRP_W-1:0]       left;
    logic [MAX_GROUP-1:0]   acc;
    logic [MAX_GROUP-1:0]   acc_next;
    logic [LEN_W-1:0]       base;

    // Length decode: shifted group base plus the tail value.
    always_comb begin
        acc_next = {acc[MAX_GROUP-2:0], bit_in};
        base     = (LEN_W'(1) << grp) - LEN_W'(1);
        run_len  = base + LEN_W'(acc_next);
        load     = take && (phase == PH_TAIL) && (left == GRP_W'(1));
    end

    // Prefix count, tail shift and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_PREFIX;
            ones  <= '0;
            grp   <= GRP_W'(1);
            left  <= '0;
            acc   <= '0;
            err   <= 1'b0;
        end else if (take) begin
            case (phase)
                PH_PREFIX: begin
                    if (bit_in) begin
                        if (ones == GRP_W'(MAX_GROUP - 1))
                            err <= 1'b1;
                        else
                            ones <= ones + GRP_W'(1);
                    end else begin
                        grp   <= ones + GRP_W'(1);
                        left  <= ones + GRP_W'(1);
                        acc   <= '0;
                        phase <= PH_TAIL;
                    end
                end
                PH_TAIL: begin
                    acc  <= acc_next;
                    left <= left - GRP_W'(1);
                    if (left == GRP_W'(1)) begin
                        phase <= PH_PREFIX;
                        ones  <= '0;
                    end
                end
                default: phase <= PH_PREFIX;
            endcase
        end
    end
endmodule

// File: rtl/asfdr_run_gen.sv
// Run generator. Loads a run length and holds shift enable for that many
// cycles with a constant bit. The bit value flips as each run ends, and
// the first run after reset is 0s. Assumes load arrives only while idle.
module asfdr_run_gen #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] run_len,
    output logic             busy,
    output logic             scan_en,
    output logic             scan_data
);
    logic [LEN_W-1:0] cnt;
    logic             pol;

    // Status from the down-counter.
    always_comb begin
        busy      = (cnt != '0);
        scan_en   = busy;
        scan_data = pol;
    end

    // Run countdown and polarity toggle on the final bit of each run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            pol <= 1'b0;
        end else if (load) begin
            cnt <= run_len;
        end else if (busy) begin
            cnt <= cnt - LEN_W'(1);
            if (cnt == LEN_W'(1))
                pol <= ~pol;
        end
    end
endmodule

// File: rtl/asfdr_decoder.sv
// Top of the decoder. Joins the tester handshake to the codeword parser
// and the parser to the run generator. The tester and scan sides share one
// clock, and a slow tester is seen as sparse valid cycles.
module asfdr_decoder
    import asfdr_pkg::*;
#(
    parameter int MAX_GROUP = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tst_valid,
    input  logic tst_bit,
    output logic tst_ready,
    output logic scan_en,
    output logic scan_data,
    output logic dec_err
);
    localparam int GRP_W = $clog2(MAX_GROUP + 1);
    localparam int LEN_W = MAX_GROUP + 1;

    logic             take;
    logic             load;
    logic             busy;
    logic [LEN_W-1:0] run_len;

    // Handshake: accept only while idle and error-free.
    always_comb begin
        tst_ready = !busy && !dec_err;
        take      = tst_valid && tst_ready;
    end

    asfdr_cw_parser #(
        .MAX_GROUP (MAX_GROUP),
        .GRP_W     (GRP_W),
        .LEN_W     (LEN_W)
    ) u_parse (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .bit_in  (tst_bit),
        .load    (load),
        .run_len (run_len),
        .err     (dec_err)
    );

    asfdr_run_gen #(
        .LEN_W (LEN_W)
    ) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .run_len   (run_len),
        .busy      (busy),
        .scan_en   (scan_en),
        .scan_data (scan_data)
    );
endmodule

// File: rtl/asfdr_decoder_chk.sv
// Assertion checker for asfdr_decoder, attached by bind.
module asfdr_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic tst_ready,
    input logic scan_en,
    input logic scan_data,
    input logic dec_err
);
    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !tst_ready);

    // R4
    run_value_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && $past(scan_en)) |-> (scan_data == $past(scan_data)));

    // R4
    run_value_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (scan_data != $past(scan_data)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> dec_err);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (!tst_ready && !scan_en));
endmodule

bind asfdr_decoder asfdr_decoder_chk chk_i (.*);

// File: tb/tb_asfdr_decoder.sv
// Directed bench for asfdr_decoder.
module tb_asfdr_decoder;
    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tst_valid = 1'b0;
    logic tst_bit = 1'b0;
    logic tst_ready, scan_en, scan_data, dec_err;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit exp_pol = 1'b0;
    int acc_cyc = 0;

    int exp_len_q[$];
    int exp_val_q[$];
    int acc_q[$];
    int got_len_q[$];
    int got_val_q[$];
    int got_start_q[$];
    int cur_len = 0;
    int cur_val = 0;
    int rdy_bad = 0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    asfdr_decoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tst_valid (tst_valid),
        .tst_bit   (tst_bit),
        .tst_ready (tst_ready),
        .scan_en   (scan_en),
        .scan_data (scan_data),
        .dec_err   (dec_err)
    );

    // Scan-side monitor: measures each run's length, value and first cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (scan_en) begin
                if (cur_len == 0) begin
                    got_start_q.push_back(cyc);
                    cur_val = int'(scan_data);
                end else if (int'(scan_data) != cur_val) begin
                    cur_val = 2;
                end
                if (tst_ready) rdy_bad++;
                cur_len++;
            end else if (cur_len != 0) begin
                got_len_q.push_back(cur_len);
                got_val_q.push_back(cur_val);
                cur_len = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tst_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_pol = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        tst_valid = 1'b1;
        tst_bit = b;
        while (!tst_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        tst_valid = 1'b0;
        repeat (GAP - 1) @(negedge clk);
    endtask

    // Bench encoder built from R2; also records the expected run.
    task automatic send_run(input int len);
        int k = 1;
        int tail;
        while (len > (1 << (k + 1)) - 2) k++;
        tail = len - ((1 << k) - 1);
        for (int i = 0; i < k - 1; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = k - 1; i >= 0; i--) send_bit(tail[i]);
        acc_q.push_back(acc_cyc);
        exp_len_q.push_back(len);
        exp_val_q.push_back(int'(exp_pol));
        exp_pol = ~exp_pol;
    endtask

    task automatic check_runs(input string tag);
        while (scan_en || !tst_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(got_len_q.size() == exp_len_q.size(), {tag, " run count"},
            got_len_q.size(), exp_len_q.size());
        for (int i = 0; i < exp_len_q.size() && i < got_len_q.size(); i++) begin
            chk(got_len_q[i] == exp_len_q[i], {tag, " length"}, got_len_q[i], exp_len_q[i]);
            chk(got_val_q[i] == exp_val_q[i], {tag, " R4 value"}, got_val_q[i], exp_val_q[i]);
            chk(got_start_q[i] == acc_q[i], {tag, " R5 start cycle"}, got_start_q[i], acc_q[i]);
        end
        chk(rdy_bad == 0, {tag, " R6 ready low in run"}, rdy_bad, 0);
        exp_len_q.delete(); exp_val_q.delete(); acc_q.delete();
        got_len_q.delete(); got_val_q.delete(); got_start_q.delete();
        rdy_bad = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(scan_en == 1'b0, "R1 scan_en", int'(scan_en), 0);
        chk(tst_ready == 1'b1, "R1 ready", int'(tst_ready), 1);
        chk(dec_err == 1'b0, "R1 err", int'(dec_err), 0);
    endtask

    task automatic t_shortest();
        send_run(1);
        send_run(2);
        send_run(1);
        check_runs("R3 shortest codes");
    endtask

    task automatic t_groups();
        send_run(3);
        send_run(6);
        send_run(7);
        send_run(14);
        send_run(15);
        send_run(100);
        check_runs("R2 group edges R9 gaps");
    endtask

    task automatic t_long();
        send_run(2000);
        send_run(2046);
        check_runs("R7 long runs");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        chk(dec_err == 1'b0, "R8 nine ones no error", int'(dec_err), 0);
        @(negedge clk);
        tst_valid = 1'b1;
        tst_bit = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(dec_err == 1'b1, "R8 error set", int'(dec_err), 1);
        chk(tst_ready == 1'b0, "R8 ready low", int'(tst_ready), 0);
        tst_bit = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (scan_en) rdy_bad++;
        end
        tst_valid = 1'b0;
        chk(rdy_bad == 0, "R8 no output", rdy_bad, 0);
        chk(dec_err == 1'b1, "R8 sticky", int'(dec_err), 1);
        rdy_bad = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_shortest();
        t_groups();
        t_long();
        t_reset();
        t_overflow();
        t_reset();
        t_shortest();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule